// File: doc/BRIEF.md
# Dual-Port Memory with Mailbox Interrupts

This block is a 2048-word by 8-bit memory with two independent ports, called left and right. Each port can read or write any word. The block also offers a simple way for the two sides to signal each other. The two highest addresses act as mailboxes, one for each direction. When one port writes the mailbox that belongs to its partner, the partner's interrupt output goes active. The partner then services the message by reading that mailbox, and this read clears the interrupt.

The mailbox words stay ordinary storage. The sender picks the 8-bit message, and the receiver reads it back like any other word. A global enable switches the mailbox behaviour on or off. While the enable is low, the two top addresses act only as memory.

Each port has its own active-high chip enable, output enable, write enable, address and write data inputs. Each port has a registered read data output and an active-low interrupt output.

Top module: `dp_mailbox_ram`

## Requirements
- R1: During a synchronous active-high reset, and right after it, both `l_irq_n` and `r_irq_n` are 1 (inactive).
- R2: A port writes `wdata` to `addr` on a clock edge where `ce`=1 and `we`=1. A port reads on an edge where `ce`=1, `oe`=1 and `we`=0. The read word appears on its `rdata` after that edge. A word written on one edge can be read by either port from the next edge onward.
- R3: The mailbox words at 0x7FE and 0x7FF store and return 8-bit data exactly like any other address.
- R4: With `mbx_en`=1, a right-port write (`r_ce`=1, `r_we`=1) to 0x7FE drives `l_irq_n` to 0 after that clock edge.
- R5: With `mbx_en`=1, a left-port access to 0x7FE with `l_ce`=1 and `l_oe`=1 returns `l_irq_n` to 1 after that edge, whatever the value of `l_we`. An access with `l_oe`=0 does not clear the flag.
- R6: With `mbx_en`=1, a left-port write to 0x7FF drives `r_irq_n` to 0 after that edge.
- R7: With `mbx_en`=1, a right-port access to 0x7FF with `r_ce`=1 and `r_oe`=1 returns `r_irq_n` to 1 after that edge, whatever the value of `r_we`.
- R8: If a flag is set and cleared on the same edge, the flag ends up asserted (0).
- R9: No other access changes a flag. This covers writes to normal addresses, a port writing its own mailbox, and a port reading or writing its partner's mailbox without writing it.
- R10: With `mbx_en`=0, no access changes either flag, and both mailbox words still work as memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mbx_en | input | 1 | Turns the mailbox interrupts on |
| l_ce | input | 1 | Left chip enable |
| l_oe | input | 1 | Left output enable |
| l_we | input | 1 | Left write enable |
| l_addr | input | 11 | Left address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left read data (registered) |
| l_irq_n | output | 1 | Left interrupt, active low (registered) |
| r_ce | input | 1 | Right chip enable |
| r_oe | input | 1 | Right output enable |
| r_we | input | 1 | Right write enable |
| r_addr | input | 11 | Right address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read data (registered) |
| r_irq_n | output | 1 | Right interrupt, active low (registered) |

## Verification
A wrong flag state shows on the interrupt pins on the very next clock edge, because each flag is a single register driven straight to its port. A set that is lost, or a clear that does not happen, shows up on the next check of the pins. A bad mailbox decode shows up as a flag that moves after an access that should leave it alone. Corrupted storage shows on the read data one cycle after the read that touches it. So each fault shows at the ports within one cycle of the access that triggers it.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic {
    PORT_L = 1'b0,
    PORT_R = 1'b1
  } port_e;

  // The receiving port owns a mailbox in the top two words:
  // the left port receives at DEPTH-2, the right port at DEPTH-1.
  function automatic int unsigned mbx_index(port_e p, int unsigned depth);
    return (p == PORT_L) ? depth - 2 : depth - 1;
  endfunction
endpackage

// File: rtl/dp_mem.sv
module dp_mem #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pa_ce,
  input  logic              pa_oe,
  input  logic              pa_we,
  input  logic [ADDR_W-1:0] pa_addr,
  input  logic [DATA_W-1:0] pa_wdata,
  output logic [DATA_W-1:0] pa_rdata,
  input  logic              pb_ce,
  input  logic              pb_oe,
  input  logic              pb_we,
  input  logic [ADDR_W-1:0] pb_addr,
  input  logic [DATA_W-1:0] pb_wdata,
  output logic [DATA_W-1:0] pb_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  // Single write process; on a same-address collision port B lands last.
  always_ff @(posedge clk) begin
    if (pa_ce && pa_we) store[pa_addr] <= pa_wdata;
    if (pb_ce && pb_we) store[pb_addr] <= pb_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)                          pa_rdata <= '0;
    else if (pa_ce && pa_oe && !pa_we) pa_rdata <= store[pa_addr];
  end

  always_ff @(posedge clk) begin
    if (rst)                          pb_rdata <= '0;
    else if (pb_ce && pb_oe && !pb_we) pb_rdata <= store[pb_addr];
  end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag #(
  parameter int                ADDR_W   = 11,
  parameter logic [ADDR_W-1:0] MBX_ADDR = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              peer_ce,
  input  logic              peer_we,
  input  logic [ADDR_W-1:0] peer_addr,
  input  logic              own_ce,
  input  logic              own_oe,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              irq_n
);
  logic hit_set;
  logic hit_clr;

  assign hit_set = enable && peer_ce && peer_we && (peer_addr == MBX_ADDR);
  assign hit_clr = enable && own_ce && own_oe && (own_addr == MBX_ADDR);

  // Set outranks clear on the same edge.
  always_ff @(posedge clk) begin
    if (rst)          irq_n <= 1'b1;
    else if (hit_set) irq_n <= 1'b0;
    else if (hit_clr) irq_n <= 1'b1;
  end
endmodule

// File: rtl/dp_mailbox_ram.sv
module dp_mailbox_ram
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mbx_en,
  input  logic              l_ce,
  input  logic              l_oe,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_irq_n,
  input  logic              r_ce,
  input  logic              r_oe,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_irq_n
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int N_PORTS = 2;

  logic              ce_v   [N_PORTS];
  logic              oe_v   [N_PORTS];
  logic              we_v   [N_PORTS];
  logic [ADDR_W-1:0] addr_v [N_PORTS];
  logic              irq_v  [N_PORTS];

  assign ce_v[0]   = l_ce;
  assign oe_v[0]   = l_oe;
  assign we_v[0]   = l_we;
  assign addr_v[0] = l_addr;
  assign ce_v[1]   = r_ce;
  assign oe_v[1]   = r_oe;
  assign we_v[1]   = r_we;
  assign addr_v[1] = r_addr;

  dp_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk      (clk),
    .rst      (rst),
    .pa_ce    (l_ce),
    .pa_oe    (l_oe),
    .pa_we    (l_we),
    .pa_addr  (l_addr),
    .pa_wdata (l_wdata),
    .pa_rdata (l_rdata),
    .pb_ce    (r_ce),
    .pb_oe    (r_oe),
    .pb_we    (r_we),
    .pb_addr  (r_addr),
    .pb_wdata (r_wdata),
    .pb_rdata (r_rdata)
  );

  for (genvar p = 0; p < N_PORTS; p++) begin : g_flag
    localparam port_e             PID  = port_e'(p);
    localparam logic [ADDR_W-1:0] MBOX = ADDR_W'(mbx_index(PID, DEPTH));
    localparam int                PEER = N_PORTS - 1 - p;

    mbx_flag #(.ADDR_W(ADDR_W), .MBX_ADDR(MBOX)) u_flag (
      .clk       (clk),
      .rst       (rst),
      .enable    (mbx_en),
      .peer_ce   (ce_v[PEER]),
      .peer_we   (we_v[PEER]),
      .peer_addr (addr_v[PEER]),
      .own_ce    (ce_v[p]),
      .own_oe    (oe_v[p]),
      .own_addr  (addr_v[p]),
      .irq_n     (irq_v[p])
    );
  end

  assign l_irq_n = irq_v[0];
  assign r_irq_n = irq_v[1];
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              mbx_en,
  input logic              l_ce,
  input logic              l_oe,
  input logic              l_we,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_irq_n,
  input logic              r_ce,
  input logic              r_oe,
  input logic              r_we,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_irq_n
);
  localparam logic [ADDR_W-1:0] BOX_L = {{(ADDR_W-1){1'b1}}, 1'b0};
  localparam logic [ADDR_W-1:0] BOX_R = {ADDR_W{1'b1}};

  logic set_l, clr_l, set_r, clr_r;
  assign set_l = mbx_en && r_ce && r_we && (r_addr == BOX_L);
  assign clr_l = mbx_en && l_ce && l_oe && (l_addr == BOX_L);
  assign set_r = mbx_en && l_ce && l_we && (l_addr == BOX_R);
  assign clr_r = mbx_en && r_ce && r_oe && (r_addr == BOX_R);

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (l_irq_n && r_irq_n));

  a_r4_left_set: assert property (@(posedge clk) disable iff (rst)
    set_l |=> !l_irq_n);

  a_r5_left_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_l && !set_l) |=> l_irq_n);

  a_r6_right_set: assert property (@(posedge clk) disable iff (rst)
    set_r |=> !r_irq_n);

  a_r7_right_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_r && !set_r) |=> r_irq_n);

  a_r9_left_hold: assert property (@(posedge clk) disable iff (rst)
    !(set_l || clr_l) |=> $stable(l_irq_n));

  a_r9_right_hold: assert property (@(posedge clk) disable iff (rst)
    !(set_r || clr_r) |=> $stable(r_irq_n));

  a_r10_disabled_frozen: assert property (@(posedge clk) disable iff (rst)
    !mbx_en |=> ($stable(l_irq_n) && $stable(r_irq_n)));
endmodule

bind dp_mailbox_ram mbx_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .mbx_en  (mbx_en),
  .l_ce    (l_ce),
  .l_oe    (l_oe),
  .l_we    (l_we),
  .l_addr  (l_addr),
  .l_irq_n (l_irq_n),
  .r_ce    (r_ce),
  .r_oe    (r_oe),
  .r_we    (r_we),
  .r_addr  (r_addr),
  .r_irq_n (r_irq_n)
);

// File: tb/sim_dp_mailbox_ram.sv
module sim_dp_mailbox_ram;
  localparam int AW = 11;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          mbx_en;
  logic          l_ce, l_oe, l_we, r_ce, r_oe, r_we;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic          l_irq_n, r_irq_n;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    bit            port;
    logic [DW-1:0] data;
    bit            chk;
    string         tag;
  } exp_t;

  exp_t          sb_q[$];
  logic [DW-1:0] ref_mem [2048];

  always #4 clk = ~clk;

  dp_mailbox_ram #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .mbx_en(mbx_en),
    .l_ce(l_ce), .l_oe(l_oe), .l_we(l_we), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
    .r_ce(r_ce), .r_oe(r_oe), .r_we(r_we), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
  );

  // Monitor: reads sampled at an edge are compared shortly after it.
  always @(posedge clk) begin
    bit rd_l, rd_r;
    rd_l = !rst && l_ce && l_oe && !l_we;
    rd_r = !rst && r_ce && r_oe && !r_we;
    #2;
    if (rd_l) compare(1'b0);
    if (rd_r) compare(1'b1);
  end

  task automatic compare(input bit port);
    exp_t e;
    logic [DW-1:0] got;
    if (sb_q.size() == 0) begin
      n_tests++; n_fail++;
      $display("FAIL scoreboard: unexpected read on port %0d", port);
      return;
    end
    e = sb_q.pop_front();
    if (!e.chk) return;
    got = port ? r_rdata : l_rdata;
    n_tests++;
    if (e.port !== port || got !== e.data) begin
      n_fail++;
      $display("FAIL %s: port %0d rdata=%h expected %h", e.tag, port, got, e.data);
    end
  endtask

  // Driver: called at a falling edge; holds inputs across one rising edge.
  task automatic cyc(input logic lce, loe, lwe, input logic [AW-1:0] la,
                     input logic [DW-1:0] ld,
                     input logic rce, roe, rwe, input logic [AW-1:0] ra,
                     input logic [DW-1:0] rd, input bit chk, input string tag);
    l_ce = lce; l_oe = loe; l_we = lwe; l_addr = la; l_wdata = ld;
    r_ce = rce; r_oe = roe; r_we = rwe; r_addr = ra; r_wdata = rd;
    if (lce && loe && !lwe) sb_q.push_back('{1'b0, ref_mem[la], chk, tag});
    if (rce && roe && !rwe) sb_q.push_back('{1'b1, ref_mem[ra], chk, tag});
    if (lce && lwe) ref_mem[la] = ld;
    if (rce && rwe) ref_mem[ra] = rd;
    @(negedge clk);
    l_ce = 0; l_oe = 0; l_we = 0; r_ce = 0; r_oe = 0; r_we = 0;
  endtask

  task automatic wr_l(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cyc(1, 0, 1, a, d, 0, 0, 0, '0, '0, 1, "");
  endtask
  task automatic wr_r(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cyc(0, 0, 0, '0, '0, 1, 0, 1, a, d, 1, "");
  endtask
  task automatic rd_l(input logic [AW-1:0] a, input string tag);
    cyc(1, 1, 0, a, '0, 0, 0, 0, '0, '0, 1, tag);
  endtask
  task automatic rd_r(input logic [AW-1:0] a, input string tag);
    cyc(0, 0, 0, '0, '0, 1, 1, 0, a, '0, 1, tag);
  endtask

  task automatic check_irq(input logic el, input logic er, input string tag);
    n_tests++;
    if (l_irq_n !== el || r_irq_n !== er) begin
      n_fail++;
      $display("FAIL %s: irq_n l/r=%b/%b expected %b/%b", tag, l_irq_n, r_irq_n, el, er);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst = 1; mbx_en = 1;
    l_ce = 0; l_oe = 0; l_we = 0; l_addr = '0; l_wdata = '0;
    r_ce = 0; r_oe = 0; r_we = 0; r_addr = '0; r_wdata = '0;
    repeat (3) @(negedge clk);
    check_irq(1, 1, "R1 during reset");
    rst = 0;
    @(negedge clk);
    check_irq(1, 1, "R1 after reset");

    // R2: plain storage across both ports, read right after write
    wr_l(11'h005, 8'hA5);
    rd_l(11'h005, "R2 left readback");
    wr_r(11'h100, 8'h3C);
    rd_l(11'h100, "R2 cross read");
    rd_r(11'h005, "R2 cross read");
    wr_l(11'h7FD, 8'hC3);
    rd_r(11'h7FD, "R2 top normal word");
    check_irq(1, 1, "R9 normal writes");

    // R4 / R5 / R3
    wr_r(11'h7FE, 8'h55);
    check_irq(0, 1, "R4 left set");
    rd_l(11'h7FE, "R3 left mailbox data");
    check_irq(1, 1, "R5 left clear by read");

    // R6 / R7 (clear with write enable high) / R3
    wr_l(11'h7FF, 8'h99);
    check_irq(1, 0, "R6 right set");
    rd_l(11'h7FF, "R3 right mailbox data");
    check_irq(1, 0, "R9 partner mailbox read");
    cyc(0, 0, 0, '0, '0, 1, 1, 1, 11'h7FF, 8'h77, 1, "");
    check_irq(1, 1, "R7 clear with we high");
    rd_r(11'h7FF, "R3 mailbox rewrite");

    // R9: own-mailbox writes and partner-mailbox reads
    wr_l(11'h7FE, 8'h11);
    check_irq(1, 1, "R9 left own mailbox");
    wr_r(11'h7FF, 8'h22);
    check_irq(1, 1, "R9 right own mailbox");
    rd_r(11'h7FE, "R3 own-written mailbox");
    check_irq(1, 1, "R9 right reads left mailbox");

    // R5: access without output enable does not clear
    wr_r(11'h7FE, 8'h66);
    check_irq(0, 1, "R4 left set again");
    wr_l(11'h7FE, 8'h67);
    check_irq(0, 1, "R5 no clear without oe");
    rd_l(11'h7FE, "R3 mailbox after own write");
    check_irq(1, 1, "R5 clear");

    // R8: set and clear on the same edge
    cyc(1, 1, 0, 11'h7FE, '0, 1, 0, 1, 11'h7FE, 8'h88, 0, "");
    check_irq(0, 1, "R8 set wins");
    rd_l(11'h7FE, "R3 collision write kept");
    check_irq(1, 1, "R5 clear after R8");

    // R10: feature disabled
    mbx_en = 0;
    wr_r(11'h7FE, 8'h5A);
    check_irq(1, 1, "R10 no set left");
    wr_l(11'h7FF, 8'hA6);
    check_irq(1, 1, "R10 no set right");
    rd_l(11'h7FE, "R10 mailbox is memory");
    rd_r(11'h7FF, "R10 mailbox is memory");
    mbx_en = 1;
    wr_l(11'h7FF, 8'h01);
    check_irq(1, 0, "R6 set before disable");
    mbx_en = 0;
    rd_r(11'h7FF, "R10 data while disabled");
    check_irq(1, 0, "R10 no clear");
    mbx_en = 1;
    rd_r(11'h7FF, "R3 mailbox data");
    check_irq(1, 1, "R7 clear by read");

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL scoreboard: %0d reads never seen, expected 0", sb_q.size());
    end
    finish_run();
  end
endmodule